// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the in-flight instructions of a speculative out-of-order core in program order, from dispatch until they retire. Each dispatched instruction gets one slot of a circular buffer, and the slot number comes back as the tag that names the instruction's result. Functional units return results over a result bus, tagged with that slot number, in any order. Until an instruction retires, the slot also serves as the place where waiting instructions read its value. A lookup port returns a slot's value as soon as the result exists, including in the cycle the result arrives.

Only the oldest slot can retire, and only after its result is present. Retirement drives a register-write port for arithmetic instructions and a store port for memory writes. A branch retires without writing anything. When a result carries a fault, nothing is written when it reaches the oldest position. The exception is signalled there and the whole buffer is emptied, so interrupts stay precise. When a branch is found to be mispredicted, every slot younger than that branch is discarded in a single cycle. The branch and all older slots go on normally.

Top module: `rob_top`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, `cm_valid` is 0 and every lookup reports a miss.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both 1, and it returns the current tail slot on `disp_tag`. Successive accepted dispatches get consecutive tags modulo 16. `disp_ready` is 0 while 16 slots are occupied, and a dispatch offered then is dropped.
- R3: A writeback to an occupied slot stores the value, the store address and the fault flag, and marks the slot ready. A writeback to an unoccupied or squashed slot has no effect.
- R4: A lookup of an occupied, ready slot reports a hit with the stored value. A lookup of a slot that is being written back in the same cycle reports a hit with the bus value. A lookup of a slot that is not ready, or not occupied, reports a miss.
- R5: `cm_valid` is 1 exactly when the oldest slot is occupied and ready. Slots retire one per cycle in dispatch order, whatever order their results arrived in.
- R6: The kind encoding is 0 = arithmetic, 1 = store, 2 = branch (3 behaves as branch). A retiring arithmetic slot raises `cm_reg_we` with its destination and value. A retiring store raises `cm_mem_we` with its address and value. A retiring branch raises neither.
- R7: A mispredict naming slot B discards every slot younger than B in that cycle. The next dispatch receives tag B+1, and the discarded slots miss on lookup.
- R8: A faulting slot retires with `cm_exc` set and no register or memory write, and only once it is the oldest. In that cycle all younger slots are emptied, and the next tag handed out is the faulting slot plus one.
- R9: No dispatch is accepted in a cycle with a mispredict or an exception retirement; `disp_ready` is 0 in that cycle.
- R10: The head and tail wrap from slot 15 to slot 0 with no loss of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Instruction kind (0 arithmetic, 1 store, 2 branch) |
| disp_dest | input | 5 | Destination register index |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | 4 | Slot given to the dispatched instruction |
| wb_valid | input | 1 | Result bus valid |
| wb_tag | input | 4 | Slot the result belongs to |
| wb_value | input | 32 | Result value (store data for stores) |
| wb_addr | input | 32 | Store address |
| wb_fault | input | 1 | Result raised an exception |
| lk_tag | input | 4 | Slot to look up |
| lk_hit | output | 1 | Looked-up value is available |
| lk_value | output | 32 | Looked-up value |
| mispredict_valid | input | 1 | Branch misprediction detected |
| mispredict_tag | input | 4 | Slot of the mispredicted branch |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_tag | output | 4 | Slot that retires |
| cm_exc | output | 1 | Retiring slot takes an exception |
| cm_reg_we | output | 1 | Register write at retirement |
| cm_reg_idx | output | 5 | Register written |
| cm_reg_data | output | 32 | Register write data |
| cm_mem_we | output | 1 | Memory write at retirement |
| cm_mem_addr | output | 32 | Memory write address |
| cm_mem_data | output | 32 | Memory write data |

## Verification
A wrong head, tail or occupancy count shows at the ports within one cycle. It appears as a wrong `disp_tag` on the next dispatch, a retirement with the wrong tag or payload, or a retirement the scoreboard never expected. A valid bit left set after a squash or exception shows as a lookup hit on a discarded slot, or as an extra retirement once that slot becomes the oldest. The bench therefore probes `disp_tag` and the lookup port right after every flush, and drains the buffer after each phase so that every mistake surfaces.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int REG_W     = 5;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int CNT_W     = TAG_W + 1;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_RSVD   = 2'd3
    } kind_e;

    typedef struct packed {
        logic              valid;
        logic              ready;
        logic              fault;
        kind_e             kind;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    // distance of a slot from the oldest one, in program order
    function automatic tag_t slot_age(tag_t slot, tag_t oldest);
        return slot - oldest;
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc,
    input  logic retire,
    input  logic squash,
    input  logic nuke,
    input  tag_t squash_tag,
    output tag_t head,
    output tag_t tail,
    output logic full
);
    cnt_t count;
    cnt_t keep;

    // slots kept by a squash: oldest through the branch itself
    assign keep = cnt_t'(slot_age(squash_tag, head)) + cnt_t'(1);
    assign full = (count == cnt_t'(ROB_DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (nuke) begin
            head  <= head + tag_t'(1);
            tail  <= head + tag_t'(1);
            count <= '0;
        end else begin
            head <= head + tag_t'(retire);
            if (squash) begin
                tail  <= squash_tag + tag_t'(1);
                count <= keep - cnt_t'(retire);
            end else begin
                tail  <= tail + tag_t'(alloc);
                count <= count + cnt_t'(alloc) - cnt_t'(retire);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        retire |-> (count != '0)); // R5
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
        retire |=> (head == tag_t'($past(head) + tag_t'(1)))); // R5
    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (rst)
        (squash && !nuke) |=> (tail == tag_t'($past(squash_tag) + tag_t'(1)))); // R7
    AST_NUKE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        nuke |=> (count == '0) && (tail == head)); // R8
endmodule

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  tag_t              alloc_tag,
    input  kind_e             alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              wb_valid,
    input  tag_t              wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_fault,
    input  logic              retire,
    input  tag_t              head,
    input  logic              squash,
    input  tag_t              squash_tag,
    input  logic              nuke,
    input  tag_t              lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_value,
    output slot_t             head_slot
);
    slot_t                slots [ROB_DEPTH];
    logic [ROB_DEPTH-1:0] kill;
    tag_t                 br_age;

    assign br_age = slot_age(squash_tag, head);

    for (genvar g = 0; g < ROB_DEPTH; g++) begin : g_kill
        assign kill[g] = nuke || (squash && (slot_age(tag_t'(g), head) > br_age));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROB_DEPTH; i++) begin
            if (rst) begin
                slots[i].valid <= 1'b0;
                slots[i].ready <= 1'b0;
            end else if (kill[i] || (retire && head == tag_t'(i))) begin
                slots[i].valid <= 1'b0;
                slots[i].ready <= 1'b0;
            end else if (alloc && alloc_tag == tag_t'(i)) begin
                slots[i].valid <= 1'b1;
                slots[i].ready <= 1'b0;
                slots[i].fault <= 1'b0;
                slots[i].kind  <= alloc_kind;
                slots[i].dest  <= alloc_dest;
            end else if (wb_valid && wb_tag == tag_t'(i) && slots[i].valid) begin
                slots[i].ready <= 1'b1;
                slots[i].value <= wb_value;
                slots[i].addr  <= wb_addr;
                slots[i].fault <= wb_fault;
            end
        end
    end

    // operand lookup with same-cycle forwarding from the result bus
    always_comb begin
        logic fwd;
        fwd      = wb_valid && (wb_tag == lk_tag) && slots[lk_tag].valid;
        lk_hit   = slots[lk_tag].valid && (slots[lk_tag].ready || fwd);
        lk_value = fwd ? wb_value : slots[lk_tag].value;
    end

    assign head_slot = slots[head];

    AST_WB_READY: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && slots[wb_tag].valid && !kill[wb_tag] && !(retire && head == wb_tag))
        |=> slots[$past(wb_tag)].ready); // R3
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !slots[alloc_tag].valid); // R2
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      disp_valid,
    input  logic [1:0]                disp_kind,
    input  logic [rob_pkg::REG_W-1:0] disp_dest,
    output logic                      disp_ready,
    output logic [rob_pkg::TAG_W-1:0] disp_tag,
    input  logic                      wb_valid,
    input  logic [rob_pkg::TAG_W-1:0] wb_tag,
    input  logic [rob_pkg::DATA_W-1:0] wb_value,
    input  logic [rob_pkg::ADDR_W-1:0] wb_addr,
    input  logic                      wb_fault,
    input  logic [rob_pkg::TAG_W-1:0] lk_tag,
    output logic                      lk_hit,
    output logic [rob_pkg::DATA_W-1:0] lk_value,
    input  logic                      mispredict_valid,
    input  logic [rob_pkg::TAG_W-1:0] mispredict_tag,
    output logic                      cm_valid,
    output logic [rob_pkg::TAG_W-1:0] cm_tag,
    output logic                      cm_exc,
    output logic                      cm_reg_we,
    output logic [rob_pkg::REG_W-1:0] cm_reg_idx,
    output logic [rob_pkg::DATA_W-1:0] cm_reg_data,
    output logic                      cm_mem_we,
    output logic [rob_pkg::ADDR_W-1:0] cm_mem_addr,
    output logic [rob_pkg::DATA_W-1:0] cm_mem_data
);
    tag_t  head, tail;
    logic  full, alloc, nuke, squash;
    slot_t head_slot;

    assign cm_valid   = head_slot.valid && head_slot.ready;
    assign nuke       = cm_valid && head_slot.fault;
    assign squash     = mispredict_valid && !nuke;
    assign disp_ready = !full && !mispredict_valid && !nuke;
    assign alloc      = disp_valid && disp_ready;
    assign disp_tag   = tail;

    rob_ptrs u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc),
        .retire     (cm_valid),
        .squash     (squash),
        .nuke       (nuke),
        .squash_tag (mispredict_tag),
        .head       (head),
        .tail       (tail),
        .full       (full)
    );

    rob_slots u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc),
        .alloc_tag  (tail),
        .alloc_kind (kind_e'(disp_kind)),
        .alloc_dest (disp_dest),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .wb_addr    (wb_addr),
        .wb_fault   (wb_fault),
        .retire     (cm_valid),
        .head       (head),
        .squash     (squash),
        .squash_tag (mispredict_tag),
        .nuke       (nuke),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_value   (lk_value),
        .head_slot  (head_slot)
    );

    assign cm_tag      = head;
    assign cm_exc      = nuke;
    assign cm_reg_we   = cm_valid && !head_slot.fault && (head_slot.kind == KIND_ALU);
    assign cm_reg_idx  = head_slot.dest;
    assign cm_reg_data = head_slot.value;
    assign cm_mem_we   = cm_valid && !head_slot.fault && (head_slot.kind == KIND_STORE);
    assign cm_mem_addr = head_slot.addr;
    assign cm_mem_data = head_slot.value;

    AST_EXC_SILENT: assert property (@(posedge clk) disable iff (rst)
        cm_exc |=> !cm_valid); // R8
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(cm_reg_we && cm_mem_we)); // R6
endmodule

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
    import rob_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disp_valid = 1'b0;
    logic [1:0] disp_kind = '0;
    logic [REG_W-1:0] disp_dest = '0;
    logic disp_ready;
    logic [TAG_W-1:0] disp_tag;
    logic wb_valid = 1'b0;
    logic [TAG_W-1:0] wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic wb_fault = 1'b0;
    logic [TAG_W-1:0] lk_tag = '0;
    logic lk_hit;
    logic [DATA_W-1:0] lk_value;
    logic mispredict_valid = 1'b0;
    logic [TAG_W-1:0] mispredict_tag = '0;
    logic cm_valid, cm_exc, cm_reg_we, cm_mem_we;
    logic [TAG_W-1:0] cm_tag;
    logic [REG_W-1:0] cm_reg_idx;
    logic [DATA_W-1:0] cm_reg_data, cm_mem_data;
    logic [ADDR_W-1:0] cm_mem_addr;

    always #2.5 clk = ~clk;

    rob_top dut (.*);

    int checks = 0;
    int fails  = 0;
    int exp_tail = 0;
    int q[$];
    logic [DATA_W-1:0] pv [ROB_DEPTH];
    logic [ADDR_W-1:0] pa [ROB_DEPTH];
    logic [REG_W-1:0]  pd [ROB_DEPTH];
    int                pk [ROB_DEPTH];
    bit                pf [ROB_DEPTH];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic disp(input int kind, input int dest, input logic [31:0] val,
                        input logic [31:0] addr, input bit flt);
        disp_valid = 1'b1;
        disp_kind  = kind[1:0];
        disp_dest  = dest[REG_W-1:0];
        #1;
        chk(disp_ready === 1'b1, "R2 dispatch ready", disp_ready, 1);
        chk(disp_tag == exp_tail[TAG_W-1:0], "R2 dispatch tag", disp_tag, exp_tail);
        pv[exp_tail] = val; pa[exp_tail] = addr; pd[exp_tail] = dest[REG_W-1:0];
        pk[exp_tail] = kind; pf[exp_tail] = flt;
        q.push_back(exp_tail);
        exp_tail = (exp_tail + 1) % ROB_DEPTH;
        @(posedge clk);
        #0.5;
        disp_valid = 1'b0;
        #0.5;
    endtask

    task automatic wb(input int t);
        wb_valid = 1'b1;
        wb_tag   = t[TAG_W-1:0];
        wb_value = pv[t];
        wb_addr  = pa[t];
        wb_fault = pf[t];
    endtask

    task automatic wb_off();
        wb_valid = 1'b0;
        wb_fault = 1'b0;
    endtask

    // scoreboard monitor: every retirement must match the oldest expected slot
    always @(negedge clk) begin
        if (!rst && cm_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R5 unexpected retirement", cm_tag, 0);
            end else begin
                int t;
                bit e_exc, e_rw, e_mw;
                t = q.pop_front();
                e_exc = pf[t];
                e_rw  = !pf[t] && pk[t] == 0;
                e_mw  = !pf[t] && pk[t] == 1;
                chk(cm_tag == t[TAG_W-1:0], "R5 retire order", cm_tag, t);
                chk({cm_exc, cm_reg_we, cm_mem_we} == {e_exc, e_rw, e_mw},
                    "R6 retire kind", {cm_exc, cm_reg_we, cm_mem_we}, {e_exc, e_rw, e_mw});
                if (e_rw)
                    chk(cm_reg_idx == pd[t] && cm_reg_data == pv[t], "R6 register write",
                        {cm_reg_idx, cm_reg_data}, {pd[t], pv[t]});
                if (e_mw)
                    chk(cm_mem_addr == pa[t] && cm_mem_data == pv[t], "R6 store write",
                        {cm_mem_addr, cm_mem_data}, {pa[t], pv[t]});
                if (e_exc) begin
                    chk(!cm_reg_we && !cm_mem_we, "R8 exception writes nothing",
                        {cm_reg_we, cm_mem_we}, 0);
                    q.delete();
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(disp_ready === 1'b1, "R1 ready after reset", disp_ready, 1);
        chk(disp_tag == 0, "R1 tag after reset", disp_tag, 0);
        chk(cm_valid === 1'b0, "R1 no retirement after reset", cm_valid, 0);
        lk_tag = 4'd0; #0.5;
        chk(lk_hit === 1'b0, "R1 lookup miss after reset", lk_hit, 0);
        tick();

        // out-of-order results, in-order retirement: arithmetic, store, branch
        disp(0, 3, 32'h11, 32'h0, 0);
        disp(1, 0, 32'h22, 32'h100, 0);
        disp(2, 0, 32'h33, 32'h0, 0);
        wb(2); lk_tag = 4'd0; #0.5;
        chk(lk_hit === 1'b0, "R4 miss on unready slot", lk_hit, 0);
        chk(cm_valid === 1'b0, "R5 no retirement before head ready", cm_valid, 0);
        tick();
        wb(1); lk_tag = 4'd1; #0.5;
        chk(lk_hit === 1'b1 && lk_value == 32'h22, "R4 same-cycle forward", lk_value, 32'h22);
        chk(cm_valid === 1'b0, "R5 head still waiting", cm_valid, 0);
        tick();
        wb(0); lk_tag = 4'd1; #0.5;
        chk(lk_hit === 1'b1 && lk_value == 32'h22, "R4 stored value lookup", lk_value, 32'h22);
        tick();
        wb_off();
        repeat (5) tick();
        chk(q.size() == 0, "R5 all three retired", q.size(), 0);

        // fill all 16 slots, crossing the wrap point
        for (int i = 0; i < ROB_DEPTH; i++)
            disp(0, i + 1, 32'h1000 + i, 32'h0, 0);
        chk(disp_ready === 1'b0, "R2 not ready when full", disp_ready, 0);
        disp_valid = 1'b1; tick(); disp_valid = 1'b0;
        for (int i = 0; i < ROB_DEPTH; i++) begin
            wb((3 + i) % ROB_DEPTH);
            tick();
        end
        wb_off();
        repeat (4) tick();
        chk(q.size() == 0, "R10 wrapped slots all retired", q.size(), 0);
        chk(disp_tag == 3, "R2 dispatch dropped while full", disp_tag, 3);

        // mispredict: slots 3..7, branch at 4
        disp(0, 5, 32'h51, 32'h0, 0);
        disp(2, 0, 32'h52, 32'h0, 0);
        disp(0, 6, 32'h53, 32'h0, 0);
        disp(0, 7, 32'h54, 32'h0, 0);
        disp(1, 0, 32'h55, 32'h200, 0);
        wb(5); tick(); wb_off();
        mispredict_valid = 1'b1; mispredict_tag = 4'd4; disp_valid = 1'b1; #0.5;
        chk(disp_ready === 1'b0, "R9 no dispatch during mispredict", disp_ready, 0);
        tick();
        mispredict_valid = 1'b0; disp_valid = 1'b0;
        repeat (3) void'(q.pop_back());
        exp_tail = 5;
        lk_tag = 4'd5; #0.5;
        chk(lk_hit === 1'b0, "R7 squashed slot misses", lk_hit, 0);
        disp(0, 9, 32'h61, 32'h0, 0);
        wb(6); lk_tag = 4'd6; tick(); wb_off(); #0.5;
        chk(lk_hit === 1'b0, "R3 writeback to squashed slot ignored", lk_hit, 0);
        wb(3); tick(); wb(4); tick(); wb(5); tick(); wb_off();
        repeat (4) tick();
        chk(q.size() == 0, "R7 only older slots and branch retired", q.size(), 0);
        chk(disp_tag == 6, "R7 tail after flush", disp_tag, 6);

        // precise exception on slot 7
        disp(0, 10, 32'h71, 32'h0, 0);
        disp(0, 11, 32'h72, 32'h0, 1);
        disp(0, 12, 32'h73, 32'h0, 0);
        wb(8); tick();
        wb(7); tick(); wb_off(); #0.5;
        chk(cm_valid === 1'b0, "R8 fault waits for head", cm_valid, 0);
        wb(6); tick(); wb_off();
        repeat (4) tick();
        chk(q.size() == 0, "R8 exception retired, younger dropped", q.size(), 0);
        chk(disp_tag == 8, "R8 tag after exception", disp_tag, 8);
        lk_tag = 4'd8; #0.5;
        chk(lk_hit === 1'b0, "R8 younger slot emptied", lk_hit, 0);
        chk(cm_valid === 1'b0, "R8 buffer idle after exception", cm_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule